// File: doc/BRIEF.md
# Phase-Accumulator Pulse Synthesizer

This block produces a square wave and a variable-duty pulse train from a single clock. It uses direct digital synthesis. A 27-bit phase register advances every clock by a 21-bit tuning word. The word is zero-extended into the low bits, so the upper six adder inputs stay at zero. The output frequency is therefore `clk * word / 2^27`. With a 2^26 Hz clock, one step of the word is exactly half a hertz.

The square wave is the top phase bit, registered once. The pulse output compares the top `DUTY_W` phase bits (4, 5 or 6 of them) against a duty word. The pulse is high while the phase slice is strictly below that word. This gives duty steps of 1/16, 1/32 or 1/64 of a period.

For higher clock rates the adder can be cut into registered segments. Each segment passes its carry forward one clock later. Skew registers in front of the segments and deskew registers behind them keep all bits aligned. The pipelined phase is then the unpipelined phase delayed by a fixed number of cycles, so the output frequency does not change. The aligned phase is also brought out so that it can be observed.

Top module: `pulse_synth`

## Requirements
- R1: The phase register is 27 bits wide. On each clock it adds the registered 21-bit tuning word, zero-extended, and wraps modulo 2^27. A word of all ones (0x1FFFFF) wraps many times with no loss of phase.
- R2: The tuning word is sampled at each clock edge and is first added at the following edge. The sum appears on `phase_out` after `LAT` further edges. `LAT` is `27/SEG_W - 1` when pipelining is on and 0 when it is off. With the defaults (`SEG_W` = 9), a word applied before edge e first shows on `phase_out` after edge e+3.
- R3: `square_out` equals bit 26 of `phase_out` as it was one clock earlier.
- R4: `pulse_out` is registered from `phase_out[26 -: DUTY_W] < duty_word`, using the duty word sampled at the same edge. A duty word of 0 keeps the pulse low. A duty word of all ones gives a high time of (2^DUTY_W-1)/2^DUTY_W of each period.
- R5: With pipelining on, every bit of `phase_out` equals the unpipelined phase delayed by exactly `LAT` clocks.
- R6: While `rst_n` is low at a clock edge, every register is cleared. After that edge, `phase_out`, `square_out` and `pulse_out` are all 0. After release with a zero word, the phase stays at 0.
- R7: A change of tuning word does not reset the phase. The phase keeps its value and advances by the new word from the step given in R2.
- R8: With a word of 2^k, the square wave has a period of exactly 2^(27-k) clocks and is high for half of it.
- R9: With a word of 2^20 and `DUTY_W` = 5, the pulse is high for 4*D of every 128 clocks, where D is the duty word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| freq_word | input | 21 | Tuning word, added to the phase's low bits |
| duty_word | input | DUTY_W | Duty threshold compared against the top phase bits |
| square_out | output | 1 | Registered top phase bit |
| pulse_out | output | 1 | Registered duty comparison |
| phase_out | output | 27 | Aligned phase value |

## Verification
A word driven before edge e first moves `phase_out` after edge e+1+LAT, which is edge e+3 with the defaults. Both outputs lag `phase_out` by one more edge. The bench drives all inputs on falling edges and samples on falling edges. It checks the latency step by step right after a word is applied. A cycle model in the bench keeps a two-deep history of the phase to match the pipeline delay. A second, unpipelined instance gives the bit-by-bit comparison. Period and duty counts are taken only over windows that are whole multiples of an exact period, and only once the pipeline has settled.

// File: rtl/pulse_synth_pkg.sv
// Package: shared helpers for the pulse synthesizer.
// Assumes the segment width divides the accumulator width.
package pulse_synth_pkg;
    // Number of adder segments for a given accumulator and segment width.
    function automatic int seg_count(input int acc_w, input int seg_w);
        return (acc_w + seg_w - 1) / seg_w;
    endfunction
endpackage

// File: rtl/dly_line.sv
// Module: dly_line
// A fixed delay of D clocks for a W-bit value, cleared by synchronous
// active-low reset. D = 0 gives a plain wire.
module dly_line #(
    parameter int W = 8,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (D == 0) begin : g_wire
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] sr [D];
        // shift the value one stage per clock
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < D; i++) sr[i] <= '0;
            end else begin
                sr[0] <= d;
                for (int i = 1; i < D; i++) sr[i] <= sr[i-1];
            end
        end
        assign q = sr[D-1];
    end
endmodule

// File: rtl/phase_accum.sv
// Module: phase_accum
// Phase accumulator. It adds a zero-extended tuning word every clock.
// With PIPE_EN = 1 the adder is split into SEG_W-bit segments. Each
// carry is registered into the next segment, segment k's input is
// skewed by k clocks, and its output is deskewed by NSEG-1-k clocks.
// The result is the plain sum delayed by NSEG-1 clocks.
// Assumes ACC_W is a multiple of SEG_W and there are at least 2 segments.
module phase_accum
    import pulse_synth_pkg::*;
#(
    parameter int ACC_W   = 27,
    parameter int FW_W    = 21,
    parameter int SEG_W   = 9,
    parameter bit PIPE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FW_W-1:0]  fw_q,
    output logic [ACC_W-1:0] phase_out
);
    localparam int NSEG = seg_count(ACC_W, SEG_W);

    if ((ACC_W % SEG_W) != 0 || NSEG < 2) begin : g_bad_cfg
        $error("phase_accum: SEG_W must divide ACC_W into 2 or more segments");
    end

    logic [ACC_W-1:0] inc_full;
    assign inc_full = ACC_W'(fw_q);

    if (!PIPE_EN) begin : g_flat
        logic [ACC_W-1:0] acc_q;
        // single-cycle full-width accumulate
        always_ff @(posedge clk) begin
            if (!rst_n) acc_q <= '0;
            else        acc_q <= acc_q + inc_full;
        end
        assign phase_out = acc_q;
    end else begin : g_pipe
        logic [NSEG-1:0]  carry_in;
        logic [ACC_W-1:0] aligned;
        assign carry_in[0] = 1'b0;

        for (genvar k = 0; k < NSEG; k++) begin : g_seg
            logic [SEG_W-1:0] inc_d;
            logic [SEG_W-1:0] seg_q;

            dly_line #(.W(SEG_W), .D(k)) u_skew (
                .clk(clk), .rst_n(rst_n),
                .d(inc_full[k*SEG_W +: SEG_W]), .q(inc_d)
            );

            if (k < NSEG - 1) begin : g_mid
                logic [SEG_W:0] sum;
                logic           carry_q;
                assign sum = {1'b0, seg_q} + {1'b0, inc_d}
                           + {{SEG_W{1'b0}}, carry_in[k]};
                // segment add with registered carry-out
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        seg_q   <= '0;
                        carry_q <= 1'b0;
                    end else begin
                        seg_q   <= sum[SEG_W-1:0];
                        carry_q <= sum[SEG_W];
                    end
                end
                assign carry_in[k+1] = carry_q;

                if (k == 0) begin : g_chk0
                    // R5: the low segment's carry marks exactly a wrap of its bits
                    a_r5_seg0_carry_wrap: assert property (@(posedge clk)
                        disable iff (!rst_n)
                        $past(rst_n) |-> (carry_q == (seg_q < $past(seg_q))));
                end
            end else begin : g_top
                // top segment adds modulo its width
                always_ff @(posedge clk) begin
                    if (!rst_n) seg_q <= '0;
                    else        seg_q <= seg_q + inc_d + SEG_W'(carry_in[k]);
                end
            end

            dly_line #(.W(SEG_W), .D(NSEG - 1 - k)) u_deskew (
                .clk(clk), .rst_n(rst_n),
                .d(seg_q), .q(aligned[k*SEG_W +: SEG_W])
            );
        end
        assign phase_out = aligned;
    end
endmodule

// File: rtl/duty_decode.sv
// Module: duty_decode
// Registers the square wave (top phase bit) and the duty pulse (top
// DUTY_W phase bits strictly below the duty word).
// Assumes the phase slice and the duty word are sampled on the same edge.
module duty_decode #(
    parameter int DUTY_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] phase_top,
    input  logic [DUTY_W-1:0] duty_word,
    output logic              square_out,
    output logic              pulse_out
);
    // register both waveform outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            square_out <= 1'b0;
            pulse_out  <= 1'b0;
        end else begin
            square_out <= phase_top[DUTY_W-1];
            pulse_out  <= (phase_top < duty_word);
        end
    end

    // R4: a zero duty word never gives a high pulse
    a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(duty_word) == '0)) |-> !pulse_out);

    // R4: a full duty word is high except in the last slot
    a_r4_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(duty_word) == {DUTY_W{1'b1}})
         && ($past(phase_top) != {DUTY_W{1'b1}})) |-> pulse_out);
endmodule

// File: rtl/pulse_synth.sv
// Module: pulse_synth (top)
// DDS square-wave and duty-pulse generator. It registers the tuning
// word, accumulates phase (optionally pipelined) and decodes the outputs.
// Assumes DUTY_W is 4..6 and SEG_W divides ACC_W.
module pulse_synth #(
    parameter int ACC_W   = 27,
    parameter int FW_W    = 21,
    parameter int DUTY_W  = 5,
    parameter int SEG_W   = 9,
    parameter bit PIPE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FW_W-1:0]   freq_word,
    input  logic [DUTY_W-1:0] duty_word,
    output logic              square_out,
    output logic              pulse_out,
    output logic [ACC_W-1:0]  phase_out
);
    logic [FW_W-1:0] fw_q;

    dly_line #(.W(FW_W), .D(1)) u_fw_reg (
        .clk(clk), .rst_n(rst_n), .d(freq_word), .q(fw_q)
    );

    phase_accum #(
        .ACC_W(ACC_W), .FW_W(FW_W), .SEG_W(SEG_W), .PIPE_EN(PIPE_EN)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .fw_q(fw_q), .phase_out(phase_out)
    );

    duty_decode #(.DUTY_W(DUTY_W)) u_decode (
        .clk(clk), .rst_n(rst_n),
        .phase_top(phase_out[ACC_W-1 -: DUTY_W]),
        .duty_word(duty_word),
        .square_out(square_out), .pulse_out(pulse_out)
    );

    // R6: a reset edge leaves every output cleared
    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!square_out && !pulse_out && (phase_out == '0)));

    // R3: the square wave follows the phase MSB one clock later
    a_r3_square_tracks_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (square_out == $past(phase_out[ACC_W-1])));
endmodule

// File: tb/pulse_synth_tb_top.sv
`timescale 1ns/1ps
module pulse_synth_tb_top;
    localparam int LAT = 2;   // 27/9 segments - 1

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] freq_word = '0;
    logic [4:0]  duty_word = '0;
    logic        sq, pl, sq_r, pl_r;
    logic [26:0] phase, phase_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pulse_synth #(.PIPE_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .duty_word(duty_word),
        .square_out(sq), .pulse_out(pl), .phase_out(phase)
    );

    pulse_synth #(.PIPE_EN(1'b0)) ref_i (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .duty_word(duty_word),
        .square_out(sq_r), .pulse_out(pl_r), .phase_out(phase_r)
    );

    // cycle model built from R1..R4, plus a history of the unpipelined instance
    logic [20:0] fw_m;
    logic [26:0] acc_m;
    logic [26:0] hist [LAT];
    logic [26:0] rhist [LAT];
    logic        sq_m, pl_m;
    wire  [26:0] exp_phase = hist[LAT-1];

    always @(posedge clk) begin
        if (!rst_n) begin
            fw_m <= '0; acc_m <= '0; sq_m <= 1'b0; pl_m <= 1'b0;
            for (int i = 0; i < LAT; i++) begin hist[i] <= '0; rhist[i] <= '0; end
        end else begin
            fw_m  <= freq_word;
            acc_m <= acc_m + 27'(fw_m);
            hist[0]  <= acc_m;
            rhist[0] <= phase_r;
            for (int i = 1; i < LAT; i++) begin
                hist[i] <= hist[i-1]; rhist[i] <= rhist[i-1];
            end
            sq_m <= exp_phase[26];
            pl_m <= (exp_phase[26:22] < duty_word);
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // run n cycles against the model; count highs and rising edges
    task automatic run_window(input int n, output int sq_hi, output int pl_hi,
                              output int sq_rise);
        logic prev;
        sq_hi = 0; pl_hi = 0; sq_rise = 0; prev = sq;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(phase == exp_phase, "R1/R2 phase", 32'(phase), 32'(exp_phase));
            check(sq == sq_m, "R3 square", 32'(sq), 32'(sq_m));
            check(pl == pl_m, "R4 pulse", 32'(pl), 32'(pl_m));
            check(phase == rhist[LAT-1], "R5 pipe vs flat", 32'(phase), 32'(rhist[LAT-1]));
            sq_hi += int'(sq);
            pl_hi += int'(pl);
            if (sq && !prev) sq_rise++;
            prev = sq;
        end
    endtask

    task automatic t_reset;
        int a, b, c;
        rst_n = 1'b0; freq_word = 21'h0; duty_word = 5'd31;
        repeat (3) @(negedge clk);
        check(phase == 0 && !sq && !pl, "R6 reset outputs", {sq, pl, 3'b0, phase}, 32'h0);
        rst_n = 1'b1;
        run_window(10, a, b, c);
        check(phase == 0, "R6 zero word holds phase", 32'(phase), 32'h0);
    endtask

    task automatic t_latency;
        int a, b, c;
        run_window(4, a, b, c);
        freq_word = 21'd12345;
        for (int e = 1; e <= 3; e++) begin
            @(negedge clk);
            check(phase == 0, "R2 not yet visible", 32'(phase), 32'h0);
        end
        @(negedge clk);
        check(phase == 27'd12345, "R2 first step", 32'(phase), 32'd12345);
        @(negedge clk);
        check(phase == 27'd24690, "R2 second step", 32'(phase), 32'd24690);
    endtask

    task automatic t_square_period(input int k);
        int hi, ph, ri, per;
        per = 1 << (27 - k);
        freq_word = 21'(1 << k);
        run_window(20, hi, ph, ri);
        run_window(2 * per, hi, ph, ri);
        check(hi == per, "R8 square high count", 32'(hi), 32'(per));
        check(ri == 2, "R8 square edges per window", 32'(ri), 32'd2);
    endtask

    task automatic t_duty(input int d);
        int hi, ph, ri;
        freq_word = 21'(1 << 20);
        duty_word = 5'(d);
        run_window(10, hi, ph, ri);
        run_window(128, hi, ph, ri);
        if (d == 0)
            check(ph == 0, "R4 zero duty", 32'(ph), 32'd0);
        check(ph == 4 * d, "R9 pulse high count", 32'(ph), 32'(4 * d));
    endtask

    task automatic t_wrap_max;
        int hi, ph, ri;
        freq_word = 21'h1FFFFF; duty_word = 5'd7;
        run_window(20, hi, ph, ri);
        run_window(4096, hi, ph, ri);
        check(ri == 63 || ri == 64, "R1 wrap with max word", 32'(ri), 32'd64);
    endtask

    task automatic t_change;
        int hi, ph, ri;
        logic [26:0] p0, p1;
        freq_word = 21'h0ABCDE;
        run_window(50, hi, ph, ri);
        freq_word = 21'h012345;
        run_window(5, hi, ph, ri);
        p0 = phase;
        run_window(1, hi, ph, ri);
        p1 = phase;
        check(p1 - p0 == 27'h012345, "R7 new step size", 32'(p1 - p0), 32'h012345);
        check(p0 != 0, "R7 phase not restarted", 32'(p0), 32'h1);
    endtask

    task automatic t_reset_midrun;
        int hi, ph, ri;
        freq_word = 21'h155555; duty_word = 5'd20;
        run_window(40, hi, ph, ri);
        rst_n = 1'b0;
        @(negedge clk);
        check(phase == 0 && !sq && !pl, "R6 mid-run reset", {sq, pl, 3'b0, phase}, 32'h0);
        rst_n = 1'b1;
        run_window(30, hi, ph, ri);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_square_period(20);
        t_square_period(18);
        t_duty(0);
        t_duty(10);
        t_duty(31);
        t_wrap_max();
        t_change();
        t_reset_midrun();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule